// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block sits beside the execution unit of a 16-bit core that can sleep. It takes over the core's program counter, stack pointer and status word while an interrupt is being entered or left. When a request arrives and the status word allows interrupts, the block saves the interrupted program counter and status word on the memory stack. It then clears the enable and sleep bits and fetches the handler address from a fixed table at the top of the address space. The block leaves the program counter pointing at that handler.

A return command reverses the process. The block reads the saved status word and then the saved program counter back from the stack. If the core was asleep when the interrupt came in, the restored sleep bits put it straight back to sleep, with no extra software step. The four clock-gating outputs follow the sleep bits of the status word. A pending interrupt that can be taken forces all four outputs low, so the clocks run before the entry steps begin.

Top module: `irq_entry_seq`

## Requirements
- R1: When status bit 3 (interrupt enable) is 0 and no return command is given, a request is not taken: irq_ack_o stays 0, busy_o stays 0 and no memory access is issued.
- R2: When a request is taken, the block writes the program counter to address SP-2 and then the status word it had on acceptance to address SP-4. SP is left 4 lower.
- R3: From the cycle after acceptance, status bits 3 to 7 read 0 and all other status bits are unchanged.
- R4: The handler address is read as one word from 0xFFFE minus twice the request index, one cycle after the second stack write. The word is loaded into the program counter, and busy_o is high for exactly the 4 cycles after the acceptance cycle.
- R5: A return command reads the status word from address SP and then the program counter from SP+2. SP ends 4 higher and busy_o is high for 3 cycles.
- R6: clk_gate_o[k] equals status bit 4+k, except in a cycle where the block is idle with a request and status bit 3 set; in that cycle all of clk_gate_o is 0.
- R7: Writes from the core to PC, SP or SR take effect at the next edge when the block is idle and not starting a sequence. While busy_o is high they are ignored.
- R8: A return command and a request in the same idle cycle give priority to the return. The request is not acknowledged in that cycle and no stack write occurs.
- R9: After an entry from a sleeping state followed by a return, clk_gate_o shows the sleep bits saved on entry.
- R10: After reset, PC, SP and SR read 0, busy_o and mem_req_o are 0, and clk_gate_o is 0.
- R11: irq_ack_o is high only in the cycle in which a request is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| irq_req_i | input | 1 | Interrupt request level |
| irq_idx_i | input | 6 | Vector index of the request |
| irq_ack_o | output | 1 | Request taken this cycle |
| reti_i | input | 1 | Return-from-interrupt command |
| busy_o | output | 1 | Sequence in progress |
| mem_req_o | output | 1 | Memory access this cycle |
| mem_we_o | output | 1 | Access is a write |
| mem_addr_o | output | 16 | Byte address, word aligned |
| mem_wdata_o | output | 16 | Write data |
| mem_rdata_i | input | 16 | Read data, valid one cycle after the read |
| core_pc_we_i | input | 1 | Core write strobe for PC |
| core_pc_i | input | 16 | Core PC value |
| core_sp_we_i | input | 1 | Core write strobe for SP |
| core_sp_i | input | 16 | Core SP value |
| core_sr_we_i | input | 1 | Core write strobe for SR |
| core_sr_i | input | 16 | Core SR value |
| pc_o | output | 16 | Program counter |
| sp_o | output | 16 | Stack pointer |
| sr_o | output | 16 | Status word |
| clk_gate_o | output | 4 | Clock-off controls, one per sleep bit |

## Verification
The assertions assume that memory answers every read with registered data in the next cycle. They also assume the core keeps the stack pointer word aligned and away from the vector table, so pushes and pops never wrap. The bench's memory model returns data with exactly one cycle of latency. Stack pointers are set to small even addresses in a separate stack region. Requests are dropped as soon as they are acknowledged, and the return command is pulsed for one idle cycle only.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
  localparam int WORD_W  = 16;
  localparam int GIE_BIT = 3;
  localparam int LP_LSB  = 4;
  localparam int LP_W    = 4;
  localparam logic [WORD_W-1:0] VEC_TOP   = 16'hFFFE;
  localparam logic [WORD_W-1:0] GIE_MASK  = WORD_W'(1) << GIE_BIT;
  localparam logic [WORD_W-1:0] LP_MASK   = WORD_W'((1 << LP_W) - 1) << LP_LSB;
  localparam logic [WORD_W-1:0] CLR_MASK  = GIE_MASK | LP_MASK;
  localparam logic [WORD_W-1:0] WORD_STEP = 16'd2;

  typedef enum logic [2:0] {
    S_IDLE,
    S_PUSH_PC,
    S_PUSH_SR,
    S_VEC_RD,
    S_VEC_LD,
    S_POP_SR,
    S_POP_PC,
    S_LD_PC
  } seq_state_e;
endpackage

// File: rtl/irq_seq_fsm.sv
module irq_seq_fsm
  import irq_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       irq_req_i,
  input  logic       gie_i,
  input  logic       reti_i,
  output seq_state_e state_o,
  output logic       accept_o,
  output logic       reti_go_o,
  output logic       wake_o,
  output logic       busy_o
);
  seq_state_e state_q, state_d;
  logic       idle;

  always_comb begin
    idle      = (state_q == S_IDLE);
    reti_go_o = idle && reti_i;
    accept_o  = idle && !reti_i && irq_req_i && gie_i;
    wake_o    = idle && irq_req_i && gie_i;
    busy_o    = !idle;
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE: begin
        if (reti_go_o)     state_d = S_POP_SR;
        else if (accept_o) state_d = S_PUSH_PC;
      end
      S_PUSH_PC: state_d = S_PUSH_SR;
      S_PUSH_SR: state_d = S_VEC_RD;
      S_VEC_RD:  state_d = S_VEC_LD;
      S_VEC_LD:  state_d = S_IDLE;
      S_POP_SR:  state_d = S_POP_PC;
      S_POP_PC:  state_d = S_LD_PC;
      S_LD_PC:   state_d = S_IDLE;
      default:   state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= S_IDLE;
    else        state_q <= state_d;
  end

  assign state_o = state_q;

  // R1: a disabled request leaves the sequencer idle
  p_hold_without_gie_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_IDLE && !gie_i && !reti_i) |=> (state_q == S_IDLE));

  // R4: entry steps run in fixed order
  p_entry_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_PUSH_SR) |=> (state_q == S_VEC_RD));

  // R8: a return beats a simultaneous request
  p_reti_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_IDLE && reti_i) |=> (state_q == S_POP_SR));
endmodule

// File: rtl/irq_seq_regs.sv
module irq_seq_regs
  import irq_seq_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seq_state_e        state_i,
  input  logic              accept_i,
  input  logic              reti_go_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [WORD_W-1:0] mem_rdata_i,
  input  logic              core_pc_we_i,
  input  logic [WORD_W-1:0] core_pc_i,
  input  logic              core_sp_we_i,
  input  logic [WORD_W-1:0] core_sp_i,
  input  logic              core_sr_we_i,
  input  logic [WORD_W-1:0] core_sr_i,
  output logic [WORD_W-1:0] pc_o,
  output logic [WORD_W-1:0] sp_o,
  output logic [WORD_W-1:0] sr_o,
  output logic [WORD_W-1:0] sr_save_o,
  output logic [IDX_W-1:0]  idx_o
);
  logic [WORD_W-1:0] pc_q, pc_d, sp_q, sp_d, sr_q, sr_d, save_q, save_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic              save_en, idx_en;

  always_comb begin
    pc_d    = pc_q;
    sp_d    = sp_q;
    sr_d    = sr_q;
    save_d  = sr_q;
    idx_d   = idx_i;
    save_en = 1'b0;
    idx_en  = 1'b0;
    unique case (state_i)
      S_IDLE: begin
        if (accept_i) begin
          save_en = 1'b1;
          idx_en  = 1'b1;
          sr_d    = sr_q & ~CLR_MASK;
        end else if (!reti_go_i) begin
          if (core_pc_we_i) pc_d = core_pc_i;
          if (core_sp_we_i) sp_d = core_sp_i;
          if (core_sr_we_i) sr_d = core_sr_i;
        end
      end
      S_PUSH_PC: sp_d = sp_q - WORD_STEP;
      S_PUSH_SR: sp_d = sp_q - WORD_STEP;
      S_VEC_RD:  ;
      S_VEC_LD:  pc_d = mem_rdata_i;
      S_POP_SR:  sp_d = sp_q + WORD_STEP;
      S_POP_PC: begin
        sr_d = mem_rdata_i;
        sp_d = sp_q + WORD_STEP;
      end
      S_LD_PC:   pc_d = mem_rdata_i;
      default:   ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= '0;
      sp_q <= '0;
      sr_q <= '0;
    end else begin
      pc_q <= pc_d;
      sp_q <= sp_d;
      sr_q <= sr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       save_q <= '0;
    else if (save_en) save_q <= save_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx_q <= '0;
    else if (idx_en) idx_q <= idx_d;
  end

  assign pc_o      = pc_q;
  assign sp_o      = sp_q;
  assign sr_o      = sr_q;
  assign sr_save_o = save_q;
  assign idx_o     = idx_q;

  // R2: each push moves the stack pointer down one word
  p_push_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_i == S_PUSH_PC || state_i == S_PUSH_SR) |=> (sp_q == $past(sp_q) - WORD_STEP));

  // R3: enable and sleep bits are clear once an entry starts
  p_sr_cleared_r3: assert property (@(posedge clk) disable iff (!rst_n)
    accept_i |=> ((sr_q & CLR_MASK) == '0));

  // R7: the program counter only moves by loads while busy
  p_pc_hold_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_i != S_IDLE && state_i != S_VEC_LD && state_i != S_LD_PC) |=> $stable(pc_q));

  // R5: a pop moves the stack pointer up one word
  p_pop_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_i == S_POP_SR) |=> (sp_q == $past(sp_q) + WORD_STEP));
endmodule

// File: rtl/irq_seq_memport.sv
module irq_seq_memport
  import irq_seq_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  seq_state_e        state_i,
  input  logic [WORD_W-1:0] pc_i,
  input  logic [WORD_W-1:0] sp_i,
  input  logic [WORD_W-1:0] sr_save_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [WORD_W-1:0] mem_addr_o,
  output logic [WORD_W-1:0] mem_wdata_o
);
  localparam int PAD_W = WORD_W - IDX_W - 1;

  logic [WORD_W-1:0] push_addr, vec_addr;

  always_comb begin
    push_addr   = sp_i - WORD_STEP;
    vec_addr    = VEC_TOP - {{PAD_W{1'b0}}, idx_i, 1'b0};
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = '0;
    mem_wdata_o = '0;
    unique case (state_i)
      S_PUSH_PC: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = push_addr;
        mem_wdata_o = pc_i;
      end
      S_PUSH_SR: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = push_addr;
        mem_wdata_o = sr_save_i;
      end
      S_VEC_RD: begin
        mem_req_o  = 1'b1;
        mem_addr_o = vec_addr;
      end
      S_POP_SR, S_POP_PC: begin
        mem_req_o  = 1'b1;
        mem_addr_o = sp_i;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/irq_seq_gate.sv
module irq_seq_gate
  import irq_seq_pkg::*;
(
  input  logic [LP_W-1:0] lp_i,
  input  logic            wake_i,
  output logic [LP_W-1:0] gate_o
);
  always_comb begin
    gate_o = wake_i ? '0 : lp_i;
  end
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_seq_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              irq_req_i,
  input  logic [IDX_W-1:0]  irq_idx_i,
  output logic              irq_ack_o,
  input  logic              reti_i,
  output logic              busy_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [WORD_W-1:0] mem_addr_o,
  output logic [WORD_W-1:0] mem_wdata_o,
  input  logic [WORD_W-1:0] mem_rdata_i,
  input  logic              core_pc_we_i,
  input  logic [WORD_W-1:0] core_pc_i,
  input  logic              core_sp_we_i,
  input  logic [WORD_W-1:0] core_sp_i,
  input  logic              core_sr_we_i,
  input  logic [WORD_W-1:0] core_sr_i,
  output logic [WORD_W-1:0] pc_o,
  output logic [WORD_W-1:0] sp_o,
  output logic [WORD_W-1:0] sr_o,
  output logic [LP_W-1:0]   clk_gate_o
);
  logic              rst_meta_q, rst_sync_q;
  seq_state_e        state;
  logic              accept, reti_go, wake;
  logic [WORD_W-1:0] sr_save;
  logic [IDX_W-1:0]  idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  irq_seq_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .irq_req_i (irq_req_i),
    .gie_i     (sr_o[GIE_BIT]),
    .reti_i    (reti_i),
    .state_o   (state),
    .accept_o  (accept),
    .reti_go_o (reti_go),
    .wake_o    (wake),
    .busy_o    (busy_o)
  );

  irq_seq_regs #(.IDX_W(IDX_W)) u_regs (
    .clk          (clk),
    .rst_n        (rst_sync_q),
    .state_i      (state),
    .accept_i     (accept),
    .reti_go_i    (reti_go),
    .idx_i        (irq_idx_i),
    .mem_rdata_i  (mem_rdata_i),
    .core_pc_we_i (core_pc_we_i),
    .core_pc_i    (core_pc_i),
    .core_sp_we_i (core_sp_we_i),
    .core_sp_i    (core_sp_i),
    .core_sr_we_i (core_sr_we_i),
    .core_sr_i    (core_sr_i),
    .pc_o         (pc_o),
    .sp_o         (sp_o),
    .sr_o         (sr_o),
    .sr_save_o    (sr_save),
    .idx_o        (idx_q)
  );

  irq_seq_memport #(.IDX_W(IDX_W)) u_mem (
    .state_i     (state),
    .pc_i        (pc_o),
    .sp_i        (sp_o),
    .sr_save_i   (sr_save),
    .idx_i       (idx_q),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o)
  );

  irq_seq_gate u_gate (
    .lp_i   (sr_o[LP_LSB +: LP_W]),
    .wake_i (wake),
    .gate_o (clk_gate_o)
  );

  assign irq_ack_o = accept;

  // R6: an accepted request always has its clocks running
  p_wake_on_ack_r6: assert property (@(posedge clk) disable iff (!rst_sync_q)
    irq_ack_o |-> (clk_gate_o == '0));

  // R11: acknowledge never repeats on consecutive cycles
  p_ack_single_r11: assert property (@(posedge clk) disable iff (!rst_sync_q)
    irq_ack_o |=> !irq_ack_o);

  // R1: memory is touched only during a sequence
  p_mem_only_busy_r1: assert property (@(posedge clk) disable iff (!rst_sync_q)
    mem_req_o |-> busy_o);
endmodule

// File: tb/irq_entry_seq_tb_top.sv
`timescale 1ns/1ps
module irq_entry_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        irq_req = 1'b0;
  logic [5:0]  irq_idx = '0;
  logic        irq_ack;
  logic        reti = 1'b0;
  logic        busy;
  logic        mem_req, mem_we;
  logic [15:0] mem_addr, mem_wdata;
  logic [15:0] mem_rdata = '0;
  logic        pc_we = 1'b0, sp_we = 1'b0, sr_we = 1'b0;
  logic [15:0] pc_in = '0, sp_in = '0, sr_in = '0;
  logic [15:0] pc, sp, sr;
  logic [3:0]  gate;

  logic [15:0] stack_m [0:255];
  logic [15:0] vec_m   [0:63];
  logic [15:0] last_rd_addr = '0;
  int          n_writes = 0;
  int          checks = 0;
  int          fails = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  irq_entry_seq dut_i (
    .clk(clk), .rst_n(rst_n),
    .irq_req_i(irq_req), .irq_idx_i(irq_idx), .irq_ack_o(irq_ack),
    .reti_i(reti), .busy_o(busy),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .core_pc_we_i(pc_we), .core_pc_i(pc_in),
    .core_sp_we_i(sp_we), .core_sp_i(sp_in),
    .core_sr_we_i(sr_we), .core_sr_i(sr_in),
    .pc_o(pc), .sp_o(sp), .sr_o(sr), .clk_gate_o(gate)
  );

  always @(posedge clk) begin
    if (mem_req && mem_we) begin
      stack_m[mem_addr[8:1]] <= mem_wdata;
      n_writes <= n_writes + 1;
    end else if (mem_req) begin
      last_rd_addr <= mem_addr;
      mem_rdata <= (mem_addr[15:7] == 9'h1FF) ? vec_m[mem_addr[6:1]] : stack_m[mem_addr[8:1]];
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic core_set(input logic [15:0] p, input logic [15:0] s, input logic [15:0] r);
    @(negedge clk);
    pc_in = p; sp_in = s; sr_in = r;
    pc_we = 1'b1; sp_we = 1'b1; sr_we = 1'b1;
    @(negedge clk);
    pc_we = 1'b0; sp_we = 1'b0; sr_we = 1'b0;
  endtask

  task automatic t_reset();
    chk("R10 pc", pc, 16'h0);
    chk("R10 sp", sp, 16'h0);
    chk("R10 sr", sr, 16'h0);
    chk("R10 busy/req", {busy, mem_req}, 2'b00);
    chk("R10 gate", gate, 4'h0);
  endtask

  task automatic t_no_gie();
    int busy_seen = 0;
    int w0 = n_writes;
    core_set(16'h0100, 16'h0200, 16'h00F0);
    @(negedge clk);
    irq_req = 1'b1; irq_idx = 6'd5;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (busy || irq_ack || mem_req) busy_seen++;
    end
    chk("R1 no activity without enable", busy_seen, 0);
    chk("R1 no writes", n_writes - w0, 0);
    chk("R6 sleep gates without enable", gate, 4'hF);
    irq_req = 1'b0;
  endtask

  task automatic t_entry(input logic [5:0] idx, input logic [15:0] p0, input logic [15:0] s0,
                         input logic [15:0] r0, input bit poke);
    int nbusy = 0;
    logic [15:0] exp_vec;
    exp_vec = 16'hFFFE - {9'd0, idx, 1'b0};
    core_set(p0, s0, r0);
    chk("R6 gate idle", gate, r0[7:4]);
    irq_req = 1'b1; irq_idx = idx;
    #1;
    chk("R11 ack in accept cycle", irq_ack, 1'b1);
    chk("R6 wake gates", gate, 4'h0);
    @(negedge clk);
    irq_req = 1'b0;
    chk("R11 ack drops", irq_ack, 1'b0);
    chk("R3 sr cleared", sr, r0 & 16'hFF07);
    if (poke) begin
      pc_in = 16'hDEAD; sp_in = 16'hBEEE; sr_in = 16'hFFFF;
      pc_we = 1'b1; sp_we = 1'b1; sr_we = 1'b1;
    end
    for (int i = 0; i < 5; i++) begin
      if (busy) nbusy++;
      @(negedge clk);
      pc_we = 1'b0; sp_we = 1'b0; sr_we = 1'b0;
    end
    chk("R4 busy cycles", nbusy, 4);
    chk("R4 vector addr", last_rd_addr, exp_vec);
    chk("R4 pc from vector", pc, 16'hC000 | {10'd0, exp_vec[6:1]});
    chk("R2 pc pushed", stack_m[8'(({16'd0, s0} - 2) >> 1)], p0);
    chk("R2 sr pushed", stack_m[8'(({16'd0, s0} - 4) >> 1)], r0);
    chk("R2 sp lowered", sp, s0 - 16'd4);
    chk("R7 sr kept", sr, r0 & 16'hFF07);
  endtask

  task automatic t_return(input logic [15:0] p0, input logic [15:0] s0, input logic [15:0] r0);
    int nbusy = 0;
    @(negedge clk);
    reti = 1'b1;
    @(negedge clk);
    reti = 1'b0;
    for (int i = 0; i < 4; i++) begin
      if (busy) nbusy++;
      @(negedge clk);
    end
    chk("R5 busy cycles", nbusy, 3);
    chk("R5 sr restored", sr, r0);
    chk("R5 pc restored", pc, p0);
    chk("R5 sp restored", sp, s0);
    chk("R9 sleep gates back", gate, r0[7:4]);
  endtask

  task automatic t_priority();
    int w0;
    stack_m[8'hC0] = 16'h0008;
    stack_m[8'hC1] = 16'h4444;
    core_set(16'h1000, 16'h0180, 16'h0008);
    w0 = n_writes;
    irq_req = 1'b1; reti = 1'b1; irq_idx = 6'd9;
    #1;
    chk("R8 no ack with return", irq_ack, 1'b0);
    @(negedge clk);
    irq_req = 1'b0; reti = 1'b0;
    repeat (3) @(negedge clk);
    chk("R8 pc from stack", pc, 16'h4444);
    chk("R8 sp", sp, 16'h0184);
    chk("R8 no stack write", n_writes - w0, 0);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) vec_m[i] = 16'hC000 | 16'(i);
    for (int i = 0; i < 256; i++) stack_m[i] = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_no_gie();
    t_entry(6'd5, 16'h1234, 16'h0200, 16'h00F8, 1'b0);
    t_return(16'h1234, 16'h0200, 16'h00F8);
    t_entry(6'd63, 16'h0ABC, 16'h0100, 16'h5A0F, 1'b1);
    t_return(16'h0ABC, 16'h0100, 16'h5A0F);
    t_entry(6'd0, 16'h2222, 16'h01F0, 16'h0038, 1'b0);
    t_return(16'h2222, 16'h01F0, 16'h0038);
    core_set(16'h0300, 16'h0120, 16'h0000);
    chk("R7 idle write pc", pc, 16'h0300);
    chk("R7 idle write sp", sp, 16'h0120);
    t_priority();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule